// File: doc/BRIEF.md
# PCI Host Bridge CPU-Side Register Block

This block is the processor-facing register file of a PCI host bridge. It sits on a 32-bit register bus with a valid/ready handshake. The register window is 0x224 bytes long and answers at two independent base addresses. Both bases reach the same storage. Inside the window the block holds these registers:
- a local copy of the bridge's own 256-byte configuration header;
- a configuration address register;
- a memory base register;
- a relocatable I/O base register;
- a configuration data port.

Accesses to the data port become single configuration read or write requests on a downstream request/acknowledge interface. The bus access stalls until the downstream side acknowledges.

Alongside the register file, the block compares every CPU address with the I/O base. When the address falls inside the 256 KiB I/O window, it reports a hit and the offset into I/O space. It also keeps four interrupt line levels. Each level is updated by interrupt events that carry a device-function number. The device number, which is the device-function number shifted right by three, selects the line. The PCI bus signalling itself is handled elsewhere.

Top module: `pci_host_regs`

## Requirements
- R1: Window offsets 0x000 to 0x0FC read and write the 64-word configuration header copy, one 32-bit word per offset, with the word selected by offset bits 7:2.
- R2: After reset the header word at offset 0x004 reads 0x02900080 and every other header word reads 0. This sets command bit 7, and status bits 4, 7 and 9.
- R3: Offset 0x1C0 is the configuration address register. It resets to 0 and stores and returns all 32 written bits.
- R4: Offset 0x1C4 is the memory base register. It resets to 0, and a write stores the value ANDed with 0xFF000001.
- R5: Offset 0x1C8 is the I/O base register and resets to 0xFE240000. A write stores the value ANDed with 0xFFFC0001, but only when bits 31:18 of the written value differ from bits 31:18 of the stored value. Otherwise the register, bit 0 included, is unchanged.
- R6: `io_hit` is 1 exactly when `bus_addr[31:18]` equals the stored I/O base bits 31:18, and `io_offset` is `bus_addr[17:0]`. Both are combinational on the address, so a base written on one clock edge applies from that edge on.
- R7: A valid 32-bit write to offset 0x220 raises `cfg_req` one cycle later with `cfg_we`=1, `cfg_addr` equal to the configuration address register and `cfg_wdata` equal to the written data. `cfg_req` and its fields are held until `cfg_ack`. `bus_ready` stays 0 until the cycle after `cfg_ack`, and only one request is ever outstanding.
- R8: A valid 32-bit read of offset 0x220 issues the same request with `cfg_we`=0. It completes one cycle after `cfg_ack` and returns the `cfg_rdata` value that was present with `cfg_ack`.
- R9: Any other offset inside the window, and any address outside both windows and the data port, reads 0 with `bus_ready`=1 in the same cycle. Writes to such addresses change no register.
- R10: The register window answers at base `ALIAS_A_BASE` and at base `ALIAS_B_BASE`, and both bases reach the same registers.
- R11: An access whose `bus_size` is not 2 (encoding 0=byte, 1=half, 2=word) completes in the same cycle with `bus_err`=1 and `bus_rdata`=0. It changes no register and issues no configuration request.
- R12: When `irq_valid`=1, `irq_out[irq_devfn>>3]` takes `irq_level` on the next clock edge if `irq_devfn>>3` is below 4. Device numbers of 4 and above leave `irq_out` unchanged, and `irq_out` resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register bus access request, held until ready |
| bus_addr | input | 32 | CPU address (register decode and I/O window decode) |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completes this cycle |
| bus_err | output | 1 | Access rejected for size |
| io_hit | output | 1 | bus_addr lies in the I/O window |
| io_offset | output | 18 | Offset of bus_addr in I/O space |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Request is a write |
| cfg_addr | output | 32 | Configuration address of the request |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Downstream completes the request |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| irq_valid | input | 1 | Interrupt level event |
| irq_devfn | input | 8 | Device-function number of the event |
| irq_level | input | 1 | New level for the routed line |
| irq_out | output | 4 | Routed interrupt line levels |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 18-bit I/O window, 64 header words, four interrupt lines, and alias bases at 0xFE200000 and 0x1E200000. The I/O base resets to a window that does not overlap either alias. These values let the same bench reach both aliases, the first and last bytes of the I/O window on either side of a relocation, and device numbers above the four routed lines. The downstream responder acknowledges after zero, three and five idle cycles. This exercises the stall of the data port at its shortest and at longer lengths.

// File: rtl/pci_host_pkg.sv
`timescale 1ns/1ps
package pci_host_pkg;
   localparam int unsigned OFF_W = 10;
   localparam logic [OFF_W-1:0] OFF_CADDR  = 10'h1C0;
   localparam logic [OFF_W-1:0] OFF_MBASE  = 10'h1C4;
   localparam logic [OFF_W-1:0] OFF_IOBASE = 10'h1C8;
   localparam logic [OFF_W-1:0] OFF_CDATA  = 10'h220;
   localparam logic [OFF_W-1:0] WIN_END    = 10'h224;
   localparam logic [31:0] MBASE_KEEP = 32'hFF00_0001;
   localparam logic [31:0] HDR_W1_RST = 32'h0290_0080;
   localparam logic [1:0]  SZ_WORD    = 2'd2;
   typedef enum logic [1:0] {PS_IDLE, PS_REQ, PS_DONE} port_st_e;
endpackage

// File: rtl/pci_host_hdr_mirror.sv
`timescale 1ns/1ps
module pci_host_hdr_mirror #(
   parameter int unsigned HDR_WORDS = 64,
   parameter int unsigned DW        = 32,
   localparam int unsigned IW       = $clog2(HDR_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   import pci_host_pkg::*;

   if (HDR_WORDS < 2 || (1 << IW) != HDR_WORDS) begin : g_bad_depth
      $error("HDR_WORDS must be a power of two of at least 2");
   end

   logic [DW-1:0] words [HDR_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(HDR_WORDS); i++)
            words[i] <= (i == 1) ? DW'(HDR_W1_RST) : '0;
      end else if (wr_en) begin
         words[idx] <= wdata;
      end
   end

   assign rdata = words[idx];

   AST_HDR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> words[$past(idx)] == $past(wdata)) else $error("hdr write lost"); // R1
endmodule

// File: rtl/pci_host_io_win.sv
`timescale 1ns/1ps
module pci_host_io_win #(
   parameter int unsigned AW       = 32,
   parameter int unsigned WIN_BITS = 18,
   parameter logic [31:0] BASE_RST = 32'hFE24_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       wdata,
   output logic [AW-1:0]       base_q,
   input  logic [AW-1:0]       cpu_addr,
   output logic                hit,
   output logic [WIN_BITS-1:0] offset
);
   localparam logic [AW-1:0] HI_MASK = {AW{1'b1}} << WIN_BITS;
   localparam logic [AW-1:0] KEEP    = HI_MASK | AW'(1);

   if (WIN_BITS < 2 || WIN_BITS >= AW) begin : g_bad_win
      $error("WIN_BITS must lie between 2 and AW-1");
   end

   logic moved;
   assign moved = ((wdata ^ base_q) & HI_MASK) != '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                base_q <= AW'(BASE_RST) & KEEP;
      else if (wr_en && moved)   base_q <= wdata & KEEP;
   end

   assign hit    = cpu_addr[AW-1:WIN_BITS] == base_q[AW-1:WIN_BITS];
   assign offset = cpu_addr[WIN_BITS-1:0];

   AST_IOBASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q & ~KEEP) == '0) else $error("io base stray bits"); // R5
   AST_IOBASE_SAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (((wdata ^ base_q) & HI_MASK) == '0) |=> $stable(base_q)) else $error("io base moved"); // R5
endmodule

// File: rtl/pci_host_cfg_port.sv
`timescale 1ns/1ps
module pci_host_cfg_port #(
   parameter int unsigned AW = 32,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          start_we,
   input  logic [AW-1:0] start_addr,
   input  logic [DW-1:0] start_wdata,
   output logic          done,
   output logic [DW-1:0] rdata_q,
   output logic          cfg_req,
   output logic          cfg_we,
   output logic [AW-1:0] cfg_addr,
   output logic [DW-1:0] cfg_wdata,
   input  logic          cfg_ack,
   input  logic [DW-1:0] cfg_rdata
);
   import pci_host_pkg::*;

   port_st_e st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= PS_IDLE;
         cfg_we    <= 1'b0;
         cfg_addr  <= '0;
         cfg_wdata <= '0;
         rdata_q   <= '0;
      end else begin
         unique case (st_q)
            PS_IDLE: if (start) begin
               st_q      <= PS_REQ;
               cfg_we    <= start_we;
               cfg_addr  <= start_addr;
               cfg_wdata <= start_wdata;
            end
            PS_REQ: if (cfg_ack) begin
               st_q    <= PS_DONE;
               rdata_q <= cfg_rdata;
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   assign cfg_req = st_q == PS_REQ;
   assign done    = st_q == PS_DONE;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_we)) else $error("req dropped"); // R7
   AST_NO_DONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |-> !done) else $error("done while pending"); // R7
   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && cfg_ack |=> done && rdata_q == $past(cfg_rdata)) else $error("ack lost"); // R8
endmodule

// File: rtl/pci_host_irq_route.sv
`timescale 1ns/1ps
module pci_host_irq_route #(
   parameter int unsigned LINES   = 4,
   parameter int unsigned DEVFN_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid,
   input  logic [DEVFN_W-1:0] ev_devfn,
   input  logic               ev_level,
   output logic [LINES-1:0]   lines_q
);
   if (LINES < 1 || LINES > (1 << (DEVFN_W - 3))) begin : g_bad_lines
      $error("LINES out of range for DEVFN_W");
   end

   logic [DEVFN_W-1:0] dev;
   assign dev = ev_devfn >> 3;

   for (genvar g = 0; g < int'(LINES); g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)                                 lines_q[g] <= 1'b0;
         else if (ev_valid && dev == DEVFN_W'(g))    lines_q[g] <= ev_level;
      end
   end

   AST_IRQ_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lines_q ^ $past(lines_q)) <= 1) else $error("several lines moved"); // R12
   AST_IRQ_HIGH_DEV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && (dev >= DEVFN_W'(LINES)) |=> $stable(lines_q)) else $error("high device routed"); // R12
endmodule

// File: rtl/pci_host_regs.sv
`timescale 1ns/1ps
module pci_host_regs #(
   parameter int unsigned AW           = 32,
   parameter int unsigned DW           = 32,
   parameter int unsigned IO_WIN_BITS  = 18,
   parameter logic [31:0] IO_BASE_RST  = 32'hFE24_0000,
   parameter int unsigned HDR_WORDS    = 64,
   parameter int unsigned IRQ_LINES    = 4,
   parameter int unsigned DEVFN_W      = 8,
   parameter logic [31:0] ALIAS_A_BASE = 32'hFE20_0000,
   parameter logic [31:0] ALIAS_B_BASE = 32'h1E20_0000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_valid,
   input  logic [AW-1:0]          bus_addr,
   input  logic                   bus_we,
   input  logic [1:0]             bus_size,
   input  logic [DW-1:0]          bus_wdata,
   output logic [DW-1:0]          bus_rdata,
   output logic                   bus_ready,
   output logic                   bus_err,
   output logic                   io_hit,
   output logic [IO_WIN_BITS-1:0] io_offset,
   output logic                   cfg_req,
   output logic                   cfg_we,
   output logic [AW-1:0]          cfg_addr,
   output logic [DW-1:0]          cfg_wdata,
   input  logic                   cfg_ack,
   input  logic [DW-1:0]          cfg_rdata,
   input  logic                   irq_valid,
   input  logic [DEVFN_W-1:0]     irq_devfn,
   input  logic                   irq_level,
   output logic [IRQ_LINES-1:0]   irq_out
);
   import pci_host_pkg::*;

   localparam int unsigned IW = $clog2(HDR_WORDS);
   localparam logic [OFF_W-1:0] HDR_END = OFF_W'(HDR_WORDS * 4);

   if (AW != 32 || DW != 32) begin : g_bad_width
      $error("register bus is fixed at 32 bits");
   end
   if (ALIAS_A_BASE[OFF_W-1:0] != '0 || ALIAS_B_BASE[OFF_W-1:0] != '0) begin : g_bad_alias
      $error("alias bases must be 1 KiB aligned");
   end
   if (HDR_WORDS * 4 > 32'h1C0) begin : g_bad_hdr
      $error("header overlaps control registers");
   end

   // ---------------- address decode ----------------
   logic [OFF_W-1:0] off;
   logic in_a, in_b, in_win, size_ok, acc_ok;
   logic is_hdr, is_caddr, is_mbase, is_iobase, is_cdata;

   assign off      = bus_addr[OFF_W-1:0];
   assign in_a     = bus_addr[AW-1:OFF_W] == ALIAS_A_BASE[AW-1:OFF_W];
   assign in_b     = bus_addr[AW-1:OFF_W] == ALIAS_B_BASE[AW-1:OFF_W];
   assign in_win   = (in_a || in_b) && (off < WIN_END);
   assign size_ok  = bus_size == SZ_WORD;
   assign acc_ok   = bus_valid && size_ok;
   assign is_hdr   = in_win && (off < HDR_END);
   assign is_caddr = in_win && (off == OFF_CADDR);
   assign is_mbase = in_win && (off == OFF_MBASE);
   assign is_iobase= in_win && (off == OFF_IOBASE);
   assign is_cdata = in_win && (off == OFF_CDATA);

   // ---------------- simple registers ----------------
   logic [AW-1:0] caddr_q, mbase_q, iobase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         caddr_q <= '0;
         mbase_q <= '0;
      end else if (acc_ok && bus_we) begin
         if (is_caddr) caddr_q <= bus_wdata;
         if (is_mbase) mbase_q <= bus_wdata & MBASE_KEEP;
      end
   end

   // ---------------- sub-blocks ----------------
   logic [DW-1:0] hdr_rdata, port_rdata;
   logic          port_done;

   pci_host_hdr_mirror #(.HDR_WORDS(HDR_WORDS), .DW(DW)) u_hdr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_ok && bus_we && is_hdr),
      .idx(off[IW+1:2]), .wdata(bus_wdata), .rdata(hdr_rdata));

   pci_host_io_win #(.AW(AW), .WIN_BITS(IO_WIN_BITS), .BASE_RST(IO_BASE_RST)) u_io (
      .clk(clk), .rst_n(rst_n),
      .wr_en(acc_ok && bus_we && is_iobase), .wdata(bus_wdata), .base_q(iobase_q),
      .cpu_addr(bus_addr), .hit(io_hit), .offset(io_offset));

   pci_host_cfg_port #(.AW(AW), .DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n),
      .start(acc_ok && is_cdata), .start_we(bus_we),
      .start_addr(caddr_q), .start_wdata(bus_wdata),
      .done(port_done), .rdata_q(port_rdata),
      .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata));

   pci_host_irq_route #(.LINES(IRQ_LINES), .DEVFN_W(DEVFN_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(irq_valid), .ev_devfn(irq_devfn), .ev_level(irq_level),
      .lines_q(irq_out));

   // ---------------- bus response ----------------
   assign bus_err   = bus_valid && !size_ok;
   assign bus_ready = bus_valid && ((!size_ok || !is_cdata) ? 1'b1 : port_done);

   always_comb begin
      bus_rdata = '0;
      if (acc_ok) begin
         if (is_hdr)         bus_rdata = hdr_rdata;
         else if (is_caddr)  bus_rdata = caddr_q;
         else if (is_mbase)  bus_rdata = mbase_q;
         else if (is_iobase) bus_rdata = iobase_q;
         else if (is_cdata)  bus_rdata = port_rdata;
      end
   end

   AST_MBASE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mbase_q & ~MBASE_KEEP) == '0) else $error("mbase stray bits"); // R4
   AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> $stable(caddr_q) && $stable(mbase_q) && $stable(iobase_q)) else $error("rejected access wrote"); // R11
   AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err && !cfg_req |=> !cfg_req) else $error("rejected access issued request"); // R11
   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> bus_ready && bus_rdata == '0) else $error("rejected access data"); // R11
endmodule

// File: tb/pci_host_regs_tb_top.sv
`timescale 1ns/1ps
module pci_host_regs_tb_top;
   localparam logic [31:0] BASE_A = 32'hFE20_0000;
   localparam logic [31:0] BASE_B = 32'h1E20_0000;
   localparam logic [31:0] RD_KEY = 32'h5A5A_0F0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        bus_valid = 0, bus_we = 0;
   logic [31:0] bus_addr = 32'h0, bus_wdata = 32'h0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_rdata;
   logic        bus_ready, bus_err, io_hit;
   logic [17:0] io_offset;
   logic        cfg_req, cfg_we, cfg_ack = 0;
   logic [31:0] cfg_addr, cfg_wdata, cfg_rdata = 32'h0;
   logic        irq_valid = 0, irq_level = 0;
   logic [7:0]  irq_devfn = 8'h0;
   logic [3:0]  irq_out;

   pci_host_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .bus_err(bus_err), .io_hit(io_hit), .io_offset(io_offset), .cfg_req(cfg_req),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack),
      .cfg_rdata(cfg_rdata), .irq_valid(irq_valid), .irq_devfn(irq_devfn),
      .irq_level(irq_level), .irq_out(irq_out));

   int checks = 0, failures = 0;
   logic running = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_hdr [64];
   logic [31:0] m_caddr, m_mbase, m_iobase;
   logic [3:0]  m_irq;
   int          dp_delay = 0;
   logic        exp_we;
   logic [31:0] exp_wdata;

   function automatic logic [31:0] m_read(input logic [9:0] o);
      if (o < 10'h100 && o[1:0] == 2'b00) return m_hdr[o[7:2]];
      case (o)
         10'h1C0: return m_caddr;
         10'h1C4: return m_mbase;
         10'h1C8: return m_iobase;
         10'h220: return m_caddr ^ RD_KEY;
         default: return 32'h0;
      endcase
   endfunction

   task automatic m_write(input logic [9:0] o, input logic [31:0] d);
      if (o < 10'h100 && o[1:0] == 2'b00) m_hdr[o[7:2]] = d;
      else if (o == 10'h1C0) m_caddr = d;
      else if (o == 10'h1C4) m_mbase = d & 32'hFF00_0001;
      else if (o == 10'h1C8) begin
         if (d[31:18] != m_iobase[31:18]) m_iobase = d & 32'hFFFC_0001;
      end
   endtask

   // per-clock comparison of window decode and interrupt lines (R6, R12)
   always @(negedge clk) begin
      if (running) begin
         chk(io_hit == (bus_addr[31:18] == m_iobase[31:18]), "R6 io_hit", {31'b0, io_hit},
             {31'b0, bus_addr[31:18] == m_iobase[31:18]});
         chk(io_offset == bus_addr[17:0], "R6 io_offset", {14'b0, io_offset}, {14'b0, bus_addr[17:0]});
         chk(irq_out == m_irq, "R12 irq_out", {28'b0, irq_out}, {28'b0, m_irq});
      end
   end

   // downstream responder (R7, R8)
   initial begin
      forever begin
         @(negedge clk);
         if (cfg_req) begin
            chk(cfg_we == exp_we, "R7/R8 cfg_we", {31'b0, cfg_we}, {31'b0, exp_we});
            chk(cfg_addr == m_caddr, "R7/R8 cfg_addr", cfg_addr, m_caddr);
            if (exp_we) chk(cfg_wdata == exp_wdata, "R7 cfg_wdata", cfg_wdata, exp_wdata);
            for (int k = 0; k < dp_delay; k++) begin
               chk(!bus_ready && cfg_req, "R7 stall while pending", {31'b0, bus_ready}, 32'h0);
               @(negedge clk);
            end
            chk(!bus_ready, "R7 ready low at ack", {31'b0, bus_ready}, 32'h0);
            cfg_rdata = cfg_addr ^ RD_KEY;
            cfg_ack = 1'b1;
            @(negedge clk);
            cfg_ack = 1'b0;
            cfg_rdata = 32'hDEAD_0000;
         end
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_acc(input logic [31:0] a, input logic we, input logic [31:0] wd,
                          input logic [1:0] sz, output logic [31:0] rd, output logic er, output int waits);
      bus_valid = 1; bus_addr = a; bus_we = we; bus_wdata = wd; bus_size = sz;
      waits = 0;
      rd = 32'hxxxx_xxxx; er = 1'bx;
      for (int n = 0; n < 64; n++) begin
         @(negedge clk);
         if (bus_ready) begin rd = bus_rdata; er = bus_err; break; end
         waits++;
      end
      @(posedge clk); #1;
      bus_valid = 0; bus_we = 0; bus_size = 2'd2;
   endtask

   task automatic reg_wr(input logic [31:0] base, input logic [9:0] o, input logic [31:0] d);
      logic [31:0] rd; logic er; int w;
      bus_acc(base + {22'b0, o}, 1'b1, d, 2'd2, rd, er, w);
      m_write(o, d);
   endtask

   task automatic reg_rd(input logic [31:0] base, input logic [9:0] o, input string tag);
      logic [31:0] rd; logic er; int w;
      bus_acc(base + {22'b0, o}, 1'b0, 32'h0, 2'd2, rd, er, w);
      chk(rd === m_read(o), tag, rd, m_read(o));
   endtask

   task automatic irq_ev(input logic [7:0] devfn, input logic lvl);
      irq_valid = 1; irq_devfn = devfn; irq_level = lvl;
      @(posedge clk); #1;
      irq_valid = 0;
      if ((devfn >> 3) < 4) m_irq[devfn >> 3] = lvl;
   endtask

   initial begin
      for (int i = 0; i < 64; i++) m_hdr[i] = 32'h0;
      m_hdr[1] = 32'h0290_0080;
      m_caddr = 0; m_mbase = 0; m_iobase = 32'hFE24_0000; m_irq = 0;
      exp_we = 0; exp_wdata = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;
      running = 1;
   end

   initial begin
      logic [31:0] rd; logic er; int w;
      @(posedge running);
      // reset state
      reg_rd(BASE_A, 10'h004, "R2 header word 1 reset");
      reg_rd(BASE_A, 10'h000, "R2 header word 0 reset");
      reg_rd(BASE_A, 10'h03C, "R2 header word 15 reset");
      reg_rd(BASE_A, 10'h1C0, "R3 caddr reset");
      reg_rd(BASE_A, 10'h1C4, "R4 mbase reset");
      reg_rd(BASE_A, 10'h1C8, "R5 iobase reset");
      chk(irq_out == 4'h0, "R12 irq reset", {28'b0, irq_out}, 32'h0);
      // header mirror and aliases
      reg_wr(BASE_A, 10'h000, 32'h1234_5678);
      reg_wr(BASE_B, 10'h014, 32'hA5A5_5A5A);
      reg_wr(BASE_A, 10'h0FC, 32'h0BAD_F00D);
      reg_wr(BASE_A, 10'h004, 32'h0000_0000);
      reg_rd(BASE_B, 10'h000, "R1 R10 word 0 via alias B");
      reg_rd(BASE_A, 10'h014, "R1 R10 word 5 via alias A");
      reg_rd(BASE_B, 10'h0FC, "R1 word 63");
      reg_rd(BASE_A, 10'h004, "R1 word 1 overwritten");
      // address register
      reg_wr(BASE_A, 10'h1C0, 32'hDEAD_BEEF);
      reg_rd(BASE_B, 10'h1C0, "R3 caddr all bits");
      // memory base
      reg_wr(BASE_B, 10'h1C4, 32'hFFFF_FFFF);
      reg_rd(BASE_A, 10'h1C4, "R4 mbase masked");
      reg_wr(BASE_A, 10'h1C4, 32'h5612_3456);
      reg_rd(BASE_A, 10'h1C4, "R4 mbase masked 2");
      // io window probes at reset base
      bus_addr = 32'hFE24_0100; @(negedge clk);
      chk(io_hit && io_offset == 18'h100, "R6 inside window", {31'b0, io_hit}, 32'h1);
      bus_addr = 32'hFE23_FFFC; @(negedge clk);
      chk(!io_hit, "R6 below window", {31'b0, io_hit}, 32'h0);
      bus_addr = 32'hFE27_FFFF; @(negedge clk);
      chk(io_hit && io_offset == 18'h3FFFF, "R6 last byte", {14'b0, io_offset}, 32'h3FFFF);
      bus_addr = 32'hFE28_0000; @(negedge clk);
      chk(!io_hit, "R6 past window", {31'b0, io_hit}, 32'h0);
      @(posedge clk); #1;
      // relocation
      reg_wr(BASE_A, 10'h1C8, 32'h1234_5677);
      bus_addr = 32'h1234_0008; @(negedge clk);
      chk(io_hit && io_offset == 18'h8, "R6 relocated next cycle", {31'b0, io_hit}, 32'h1);
      @(posedge clk); #1;
      reg_rd(BASE_A, 10'h1C8, "R5 iobase masked");
      reg_wr(BASE_A, 10'h1C8, 32'h1237_FFF0);
      reg_rd(BASE_A, 10'h1C8, "R5 same upper bits ignored");
      chk(m_iobase == 32'h1234_0001, "R5 model sanity", m_iobase, 32'h1234_0001);
      // data port write, delay 3
      reg_wr(BASE_A, 10'h1C0, 32'h8000_1004);
      exp_we = 1; exp_wdata = 32'hCAFE_F00D; dp_delay = 3;
      bus_acc(BASE_A + 32'h220, 1'b1, 32'hCAFE_F00D, 2'd2, rd, er, w);
      chk(w == 5, "R7 write stall length", w, 5);
      // data port reads
      exp_we = 0; dp_delay = 0;
      reg_rd(BASE_B, 10'h220, "R8 read no delay");
      reg_wr(BASE_A, 10'h1C0, 32'h8000_2210);
      dp_delay = 5;
      bus_acc(BASE_A + 32'h220, 1'b0, 32'h0, 2'd2, rd, er, w);
      chk(rd == (32'h8000_2210 ^ RD_KEY), "R8 read data", rd, 32'h8000_2210 ^ RD_KEY);
      chk(w == 7, "R8 read stall length", w, 7);
      // unmapped offsets
      reg_rd(BASE_A, 10'h100, "R9 hole 0x100 reads zero");
      reg_rd(BASE_A, 10'h1CC, "R9 hole 0x1CC reads zero");
      bus_acc(32'h0000_1000, 1'b0, 32'h0, 2'd2, rd, er, w);
      chk(rd == 0 && w == 0, "R9 outside windows", rd, 32'h0);
      reg_wr(BASE_A, 10'h100, 32'hFFFF_FFFF);
      reg_wr(BASE_A, 10'h1BC, 32'hFFFF_FFFF);
      reg_rd(BASE_A, 10'h100, "R9 hole write ignored");
      reg_rd(BASE_A, 10'h0FC, "R9 header untouched");
      reg_rd(BASE_A, 10'h1C0, "R9 caddr untouched");
      // size errors
      bus_acc(BASE_A + 32'h004, 1'b0, 32'h0, 2'd1, rd, er, w);
      chk(er === 1'b1 && rd == 0 && w == 0, "R11 half read rejected", rd, 32'h0);
      bus_acc(BASE_A + 32'h1C4, 1'b1, 32'h0100_0000, 2'd0, rd, er, w);
      chk(er === 1'b1, "R11 byte write flagged", {31'b0, er}, 32'h1);
      reg_rd(BASE_A, 10'h1C4, "R11 mbase unchanged after byte write");
      bus_acc(BASE_A + 32'h220, 1'b1, 32'h1, 2'd3, rd, er, w);
      @(negedge clk);
      chk(!cfg_req, "R11 no request on bad size", {31'b0, cfg_req}, 32'h0);
      @(posedge clk); #1;
      // interrupt routing
      irq_ev(8'h08, 1'b1);
      irq_ev(8'h1F, 1'b1);
      @(negedge clk);
      chk(irq_out == 4'b1010, "R12 dev1 and dev3 raised", {28'b0, irq_out}, 32'hA);
      @(posedge clk); #1;
      irq_ev(8'h28, 1'b1);
      irq_ev(8'hF8, 1'b1);
      @(negedge clk);
      chk(irq_out == 4'b1010, "R12 dev5 and dev31 ignored", {28'b0, irq_out}, 32'hA);
      @(posedge clk); #1;
      irq_ev(8'h0F, 1'b0);
      irq_ev(8'h00, 1'b1);
      @(negedge clk);
      chk(irq_out == 4'b1001, "R12 dev1 cleared dev0 raised", {28'b0, irq_out}, 32'h9);
      repeat (2) @(posedge clk);
      running = 0;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule